// File: doc/BRIEF.md
# Random Generator Status and Alarm Controller

This block is the register front end for a hardware random number source. A word-addressed 32-bit register port gives software four data words that hold one 128-bit random result. It also holds a status register that software clears by writing ones, a control register with a generator enable and per-event interrupt enables, a refill timing configuration and an alarm threshold. The block raises one level interrupt.

Sampling of new results is paced by a ready handshake. When software acknowledges the ready bit, the block waits a programmed minimum number of cycles. It then captures the next word that the entropy source offers and sets ready again. The captured word stays frozen until the next acknowledge.

Failure pulses from an external health monitor set sticky status bits and advance an alarm counter. When the counter reaches the threshold for the first time, one oscillator is stopped. When it reaches the threshold again while any oscillator is still stopped, all oscillators are stopped and a shutdown-overflow event is flagged. Software restarts the oscillators by writing all ones to the re-arm register.

Top module: `rng_alarm_ctrl`

## Requirements
- R1: After reset the control word, configuration word, status word, stopped-oscillator mask and alarm count read zero. The threshold reads 0xFF, the oscillator-enable read at 0x30 returns 0xFF, `irq` is low and the generator is disabled.
- R2: Status layout: bit 0 is data ready and bit 1 is shutdown overflow. A pulse on `fail_in[k]` sets status bit k+2, giving bit 2 stuck output, bit 3 noise, bit 4 run, bit 5 long run, bit 6 poker and bit 7 monobit.
- R3: A write to the status register at 0x28 clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: Random word n (n = 0..3) reads at byte offset 4n and holds bits 32n+31:32n of the captured 128-bit result. The result does not change while ready is set.
- R5: When the generator is enabled and a word is offered, ready rises on the (min+1)-th clock edge after the acknowledge or enable edge, where min is config bits 7:0. If no word is offered at that point, ready rises on the first edge at which one is offered. `src_take` is high in the cycle of capture. Writing 1 to status bit 0 while ready is set clears ready.
- R6: While control bit 10 is 0, ready is never set.
- R7: Control register 0x20 keeps bit 10 (enable) and bits 7:1 (interrupt enables); other bits read 0. Config register 0x24 keeps min refill in bits 7:0 and max refill in bits 31:16. The max value, scaled by 64, caps the wait counter once min has passed.
- R8: `irq` is the OR over bits 7:1 of (status bit AND control bit of the same index).
- R9: Each cycle with any failure pulse counts one alarm. The alarm that brings the count to the threshold (register 0x2C, bits 7:0) resets the count. If no oscillator is stopped, it stops oscillator 0, so mask 0x34 reads 0x01 and `osc_en` drops bit 0.
- R10: A threshold hit while any oscillator is stopped sets status bit 1 and stops all oscillators.
- R11: Writing all ones in bits 7:0 to 0x30 clears the stopped mask and the alarm count. Any other value written there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fail_in | input | 6 | Health monitor failure pulses |
| src_valid | input | 1 | Entropy source offers a word |
| src_data | input | 128 | Offered random word |
| src_take | output | 1 | Offered word is captured this cycle |
| osc_en | output | 8 | Per-oscillator run enables |
| irq | output | 1 | Level interrupt |

## Verification
A refill counter in the wrong state moves the edge at which ready rises. The bench reads status once per cycle after each acknowledge, so an error of a single cycle shows up at once. A wrong alarm count or threshold comparison appears on `osc_en` on the edge of the failure pulse that should hit, and on the stopped mask one read later. Sticky status flops that clear wrongly or set twice show up both in the status read and in `irq` in the cycle after the write.

// File: rtl/rng_ctl_pkg.sv
package rng_ctl_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h20;
  localparam logic [7:0] OFS_CFG  = 8'h24;
  localparam logic [7:0] OFS_STAT = 8'h28;
  localparam logic [7:0] OFS_THR  = 8'h2C;
  localparam logic [7:0] OFS_ARM  = 8'h30;
  localparam logic [7:0] OFS_STOP = 8'h34;

  localparam int N_FAIL     = 6;
  localparam int ST_W       = N_FAIL + 2;
  localparam int CTL_EN_BIT = 10;
  localparam int MIN_W      = 8;
  localparam int MAX_W      = 16;
  localparam int MAX_LSB    = 16;
  localparam int TH_W       = 8;

  typedef struct packed {
    logic              en;
    logic [ST_W-1:1]   ie;
  } ctrl_t;
endpackage

// File: rtl/rng_refill.sv
module rng_refill #(
  parameter int DATA_W   = 128,
  parameter int MIN_W    = 8,
  parameter int MAX_W    = 16,
  parameter int SCALE_SH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ack,
  input  logic [MIN_W-1:0]  min_cyc,
  input  logic [MAX_W-1:0]  max_cyc,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              ready,
  output logic              take,
  output logic [DATA_W-1:0] data
);
  localparam int CNT_W = MAX_W + SCALE_SH;

  logic [CNT_W-1:0]  cnt_q, cnt_d, limit;
  logic              rdy_q, rdy_d, at_min;
  logic [DATA_W-1:0] dat_q;

  assign limit  = (max_cyc == '0) ? '1 : {max_cyc, {SCALE_SH{1'b0}}};
  assign at_min = cnt_q >= CNT_W'(min_cyc);

  always_comb begin
    rdy_d = rdy_q;
    cnt_d = cnt_q;
    take  = 1'b0;
    if (rdy_q) begin
      cnt_d = '0;
      if (ack) rdy_d = 1'b0;
    end else if (enable) begin
      if (src_valid && at_min) begin
        take  = 1'b1;
        rdy_d = 1'b1;
        cnt_d = '0;
      end else if (!at_min || cnt_q < limit) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (take) dat_q <= src_data;
  end

  assign ready = rdy_q;
  assign data  = dat_q;
endmodule

// File: rtl/rng_alarm.sv
module rng_alarm #(
  parameter int N_OSC = 8,
  parameter int TH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_any,
  input  logic [TH_W-1:0]  thresh,
  input  logic             rearm,
  output logic [N_OSC-1:0] stopped,
  output logic             ovf_set
);
  logic [TH_W-1:0]  cnt_q, cnt_d;
  logic [N_OSC-1:0] stop_q, stop_d;
  logic [TH_W:0]    cnt_next;
  logic             hit;

  assign cnt_next = {1'b0, cnt_q} + 1'b1;
  assign hit      = fail_any && (cnt_next >= {1'b0, thresh});

  always_comb begin
    cnt_d   = cnt_q;
    stop_d  = stop_q;
    ovf_set = 1'b0;
    if (rearm) begin
      cnt_d  = '0;
      stop_d = '0;
    end else if (hit) begin
      cnt_d = '0;
      if (stop_q == '0) begin
        stop_d = N_OSC'(1);
      end else begin
        stop_d  = '1;
        ovf_set = 1'b1;
      end
    end else if (fail_any) begin
      cnt_d = cnt_next[TH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stop_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      stop_q <= stop_d;
    end
  end

  assign stopped = stop_q;
endmodule

// File: rtl/rng_status.sv
module rng_status #(
  parameter int N_FAIL = 6,
  localparam int ST_W  = N_FAIL + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_FAIL-1:0] fail_in,
  input  logic            ovf_set,
  input  logic            ready,
  input  logic            clr_wr,
  input  logic [ST_W-1:0] clr_mask,
  input  logic [ST_W-1:1] irq_en,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic [ST_W-1:1] set_vec;
  logic [ST_W-1:1] st_q;

  assign set_vec = {fail_in, ovf_set};

  for (genvar b = 1; b < ST_W; b++) begin : g_bit
    logic bit_d;
    always_comb begin
      bit_d = st_q[b];
      if (clr_wr && clr_mask[b]) bit_d = 1'b0;
      if (set_vec[b])            bit_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[b] <= 1'b0;
      else        st_q[b] <= bit_d;
    end
  end

  logic unused_clr0;
  assign unused_clr0 = clr_mask[0];

  assign status = {st_q, ready};
  assign irq    = |(st_q & irq_en);
endmodule

// File: rtl/rng_alarm_ctrl.sv
module rng_alarm_ctrl
  import rng_ctl_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int N_OSC    = 8,
  parameter int SCALE_SH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_FAIL-1:0] fail_in,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_take,
  output logic [N_OSC-1:0]  osc_en,
  output logic              irq
);
  localparam int N_WORDS = DATA_W / 32;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // write decode
  logic wr_ctrl, wr_cfg, wr_stat, wr_thr, wr_arm;
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_cfg  = reg_wr && (reg_addr == OFS_CFG);
  assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
  assign wr_thr  = reg_wr && (reg_addr == OFS_THR);
  assign wr_arm  = reg_wr && (reg_addr == OFS_ARM);

  // software registers
  ctrl_t             ctrl_q, ctrl_d;
  logic [MIN_W-1:0]  min_q, min_d;
  logic [MAX_W-1:0]  max_q, max_d;
  logic [TH_W-1:0]   thr_q, thr_d;

  always_comb begin
    ctrl_d = ctrl_q;
    min_d  = min_q;
    max_d  = max_q;
    thr_d  = thr_q;
    if (wr_ctrl) begin
      ctrl_d.en = reg_wdata[CTL_EN_BIT];
      ctrl_d.ie = reg_wdata[ST_W-1:1];
    end
    if (wr_cfg) begin
      min_d = reg_wdata[MIN_W-1:0];
      max_d = reg_wdata[MAX_LSB +: MAX_W];
    end
    if (wr_thr) thr_d = reg_wdata[TH_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      min_q  <= '0;
      max_q  <= '0;
      thr_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      min_q  <= min_d;
      max_q  <= max_d;
      thr_q  <= thr_d;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[15:11], reg_wdata[9:8]};

  // refill handshake
  logic              ready, ack;
  logic [DATA_W-1:0] rnd_q;
  assign ack = wr_stat && reg_wdata[0];

  rng_refill #(
    .DATA_W  (DATA_W),
    .MIN_W   (MIN_W),
    .MAX_W   (MAX_W),
    .SCALE_SH(SCALE_SH)
  ) i_refill (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .enable   (ctrl_q.en),
    .ack      (ack),
    .min_cyc  (min_q),
    .max_cyc  (max_q),
    .src_valid(src_valid),
    .src_data (src_data),
    .ready    (ready),
    .take     (src_take),
    .data     (rnd_q)
  );

  // alarm / oscillator bookkeeping
  logic [N_OSC-1:0] stopped;
  logic             ovf_set, rearm;
  assign rearm = wr_arm && (reg_wdata[N_OSC-1:0] == '1);

  rng_alarm #(
    .N_OSC(N_OSC),
    .TH_W (TH_W)
  ) i_alarm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fail_any(|fail_in),
    .thresh  (thr_q),
    .rearm   (rearm),
    .stopped (stopped),
    .ovf_set (ovf_set)
  );

  assign osc_en = ~stopped;

  // status and interrupt
  logic [ST_W-1:0] status;

  rng_status #(
    .N_FAIL(N_FAIL)
  ) i_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fail_in (fail_in),
    .ovf_set (ovf_set),
    .ready   (ready),
    .clr_wr  (wr_stat),
    .clr_mask(reg_wdata[ST_W-1:0]),
    .irq_en  (ctrl_q.ie),
    .status  (status),
    .irq     (irq)
  );

  // read path
  logic [31:0] word [N_WORDS];
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign word[w] = rnd_q[32*w +: 32];
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (reg_addr == 8'(4 * w)) reg_rdata = word[w];
    end
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CTL_EN_BIT] = ctrl_q.en;
        reg_rdata[ST_W-1:1]   = ctrl_q.ie;
      end
      OFS_CFG: begin
        reg_rdata[MIN_W-1:0]        = min_q;
        reg_rdata[MAX_LSB +: MAX_W] = max_q;
      end
      OFS_STAT: reg_rdata[ST_W-1:0]  = status;
      OFS_THR:  reg_rdata[TH_W-1:0]  = thr_q;
      OFS_ARM:  reg_rdata[N_OSC-1:0] = osc_en;
      OFS_STOP: reg_rdata[N_OSC-1:0] = stopped;
      default: ;
    endcase
  end
endmodule

// File: rtl/rng_alarm_ctrl_chk.sv
module rng_alarm_ctrl_chk #(
  parameter int N_OSC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             ack,
  input logic             enable,
  input logic             take,
  input logic             rearm,
  input logic [N_OSC-1:0] stopped,
  input logic             ovf_bit
);
  // R5: ready stays set until acknowledged
  a_r5_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ack) |=> ready);

  // R5: acknowledge drops ready
  a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ack) |=> !ready);

  // R5: a capture always leaves ready set
  a_r5_take_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ready);

  // R6: no refill while the generator is disabled
  a_r6_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !ready) |=> !ready);

  // R11: stopped oscillators only restart through re-arm
  a_r11_stop_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !rearm |=> ((stopped & $past(stopped)) == $past(stopped)));

  // R10: overflow only when an oscillator was already stopped
  a_r10_ovf_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_bit) |-> ($past(stopped) != '0));
endmodule

bind rng_alarm_ctrl rng_alarm_ctrl_chk #(.N_OSC(N_OSC)) i_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .ready  (ready),
  .ack    (ack),
  .enable (ctrl_q.en),
  .take   (src_take),
  .rearm  (rearm),
  .stopped(stopped),
  .ovf_bit(status[1])
);

// File: tb/test_rng_alarm_ctrl.sv
module test_rng_alarm_ctrl;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr;
  logic [7:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [5:0]   fail_in;
  logic         src_valid;
  logic [127:0] src_data;
  logic         src_take;
  logic [7:0]   osc_en;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rng_alarm_ctrl i_rng_alarm_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fail_in(fail_in),
    .src_valid(src_valid), .src_data(src_data), .src_take(src_take),
    .osc_en(osc_en), .irq(irq)
  );

  typedef struct {
    logic [7:0]  a;
    logic [31:0] e;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  event rd_ev;

  // monitor: pops expected reads and compares
  initial begin
    exp_t it;
    forever begin
      @(rd_ev);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_chk++;
        if (reg_rdata !== it.e) begin
          n_bad++;
          $display("FAIL %s addr 0x%02h actual 0x%08h expected 0x%08h",
                   it.tag, it.a, reg_rdata, it.e);
        end
      end
    end
  end

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    sb_q.push_back('{a, e, tag});
    -> rd_ev;
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk);
    fail_in = v;
    @(negedge clk);
    fail_in = '0;
  endtask

  localparam logic [127:0] D1 = 128'hA5A5_0001_1357_9BDF_0246_8ACE_DEAD_BEEF;
  localparam logic [127:0] D2 = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    fail_in = '0; src_valid = 1'b0; src_data = D1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_exp(8'h20, 32'h0, "R1 ctrl");
    rd_exp(8'h24, 32'h0, "R1 cfg");
    rd_exp(8'h28, 32'h0, "R1 status");
    rd_exp(8'h2C, 32'hFF, "R1 threshold");
    rd_exp(8'h34, 32'h0, "R1 stopped");
    rd_exp(8'h30, 32'hFF, "R1 osc read");
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 osc_en", {24'b0, osc_en}, 32'hFF);
    rd_exp(8'h3C, 32'h0, "R1 unmapped");

    // R7 configuration readback
    wr(8'h24, 32'h0002_0003);
    rd_exp(8'h24, 32'h0002_0003, "R7 cfg");
    wr(8'h2C, 32'h0000_0002);
    rd_exp(8'h2C, 32'h2, "R7 threshold");

    // R5 refill after enable, min = 3
    src_valid = 1'b1;
    wr(8'h20, 32'h0000_FFFF);
    rd_exp(8'h28, 32'h0, "R5 k1");
    rd_exp(8'h28, 32'h0, "R5 k2");
    rd_exp(8'h28, 32'h0, "R5 k3");
    chk("R5 take", {31'b0, src_take}, 32'h1);
    rd_exp(8'h28, 32'h1, "R5 k4");
    rd_exp(8'h20, 32'h0000_04FE, "R7 ctrl");
    wr(8'h20, 32'h0000_0400);

    // R4 data words and freeze while ready
    src_data = D2;
    for (int w = 0; w < 4; w++) rd_exp(8'(4 * w), D1[32*w +: 32], "R4 word");
    chk("R5 no take while ready", {31'b0, src_take}, 32'h0);

    // R5 acknowledge then refill with next word
    wr(8'h28, 32'h1);
    rd_exp(8'h28, 32'h0, "R5 ack k1");
    rd_exp(8'h28, 32'h0, "R5 ack k2");
    rd_exp(8'h28, 32'h0, "R5 ack k3");
    rd_exp(8'h28, 32'h1, "R5 ack k4");
    for (int w = 0; w < 4; w++) rd_exp(8'(4 * w), D2[32*w +: 32], "R4 word2");

    // R5 no word offered: wait, then capture on first offer
    src_valid = 1'b0;
    wr(8'h28, 32'h1);
    repeat (10) @(negedge clk);
    rd_exp(8'h28, 32'h0, "R5 no word");
    src_data = D1;
    src_valid = 1'b1;
    rd_exp(8'h28, 32'h1, "R5 late word");
    rd_exp(8'h0C, D1[127:96], "R4 word3 late");

    // R6 disabled: no refill
    wr(8'h20, 32'h0);
    wr(8'h28, 32'h1);
    repeat (10) @(negedge clk);
    rd_exp(8'h28, 32'h0, "R6 disabled");

    // R2 failure bits; alarm count becomes 1
    pulse(6'b100001);
    rd_exp(8'h28, 32'h84, "R2 monobit+stuck");
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h20, 32'h80);
    chk("R8 irq enabled", {31'b0, irq}, 32'h1);

    // R3 write-one-to-clear
    wr(8'h28, 32'h04);
    rd_exp(8'h28, 32'h80, "R3 partial clear");
    wr(8'h28, 32'h80);
    rd_exp(8'h28, 32'h0, "R3 full clear");
    chk("R8 irq after clear", {31'b0, irq}, 32'h0);

    // R9 second failure reaches threshold 2: stop oscillator 0
    pulse(6'b000010);
    chk("R9 osc_en", {24'b0, osc_en}, 32'hFE);
    rd_exp(8'h34, 32'h01, "R9 stopped");
    rd_exp(8'h28, 32'h08, "R2 noise");
    wr(8'h28, 32'hFF);

    // R10 threshold again with oscillator stopped
    wr(8'h20, 32'h02);
    pulse(6'b000001);
    rd_exp(8'h34, 32'h01, "R10 one alarm");
    chk("R8 irq before ovf", {31'b0, irq}, 32'h0);
    pulse(6'b000001);
    rd_exp(8'h28, 32'h06, "R10 overflow");
    rd_exp(8'h34, 32'hFF, "R10 all stopped");
    chk("R10 osc_en", {24'b0, osc_en}, 32'h00);
    chk("R8 irq ovf", {31'b0, irq}, 32'h1);

    // R11 re-arm
    wr(8'h30, 32'h0F);
    rd_exp(8'h34, 32'hFF, "R11 partial ignored");
    wr(8'h30, 32'hFF);
    rd_exp(8'h34, 32'h00, "R11 rearmed");
    chk("R11 osc_en", {24'b0, osc_en}, 32'hFF);
    pulse(6'b000100);
    rd_exp(8'h34, 32'h00, "R11 count cleared");
    wr(8'h28, 32'hFF);
    rd_exp(8'h28, 32'h0, "R3 clear all");

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule